// File: doc/BRIEF.md
# Fixed-Priority Maskable Interrupt Controller

This block arbitrates the maskable interrupt requests of a small 8-bit microcontroller. Fifteen request slots are served: four external pins, two serial UARTs, a synchronous serial port, five timer/counters, an analog converter, a watchdog and a watch timer that share one slot, and an interval timer whose request comes from a counter overflow. A one-cycle event pulse from a source sets a sticky request flag. A flag takes part in arbitration only when its own enable bit is set and the global master enable is on. Among the qualifying slots, the one with the highest fixed priority wins. Its 4-bit slot index and a level request go to the CPU.

The CPU acknowledges the presented request with a one-cycle pulse. The acknowledge clears the winning flag and drops the master enable, so a second interrupt cannot be taken until software turns the master enable back on. Each UART's request flag is set by a completed reception or by a completed transmission. A separate direction register records which of the two happened. Software reaches every register over a simple 8-bit register bus. Writes take effect at the next clock edge, and reads are combinational.

Top module: `irqc_top`

## Requirements
- R1: After reset both enable registers, both flag registers, the direction register and the master enable read 0x00, `irq_req` is 0 and `irq_idx` is 0.
- R2: A source pulse sets its flag in the next cycle. Flags read at 0xEC (high) and 0xED (low), laid out like the enables: high byte bit7..0 = INT0, INT1, INT2, INT3, UART0, UART1, SIO, T0; low byte bit7..0 = T1, T2, T3, T4, ADC, WDT, WT, BIT.
- R3: The high enable register at 0xEA and the low enable register at 0xEB are read/write, with the same bit layout as the flags in R2.
- R4: A flag whose enable bit is 0 never raises `irq_req`, even when the flag is set.
- R5: The master enable is bit 2 of the register at 0xEF. While it is 0, `irq_req` stays 0 whatever the enables and flags hold.
- R6: Slot indices follow fixed priority, highest first: INT0=1, INT1=2, INT2=3, INT3=4, UART0=5, UART1=6, SIO=7, T0=8, T1=9, T2=10, T3=11, T4=12, ADC=13, WDT/WT=14, BIT=15. `irq_idx` names the lowest-numbered qualifying slot.
- R7: Slot 14 qualifies when the WDT flag and its enable are both set, or when the WT flag and its enable are both set. An acknowledge of slot 14 clears the WDT flag if that flag qualifies, and the WT flag otherwise.
- R8: An acknowledge while `irq_req` is 1 clears the winning flag and the master enable in the next cycle. Other flags are left alone.
- R9: An acknowledge while `irq_req` is 0 changes no flag and leaves the master enable as it is.
- R10: Writing a flag register clears each flag whose written bit is 0. A written 1 neither sets nor clears. A source pulse in the same cycle as a clear wins, and the flag ends set.
- R11: A UART flag is set by reception or transmission done. The direction register at 0xEE records UART0 rx in bit 0, UART0 tx in bit 1, UART1 rx in bit 2 and UART1 tx in bit 3. Writing 0 to a direction bit clears it.
- R12: With no qualifying slot, `irq_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ext_irq | input | 4 | External pin events, bit n = INTn |
| uart_rx_done | input | 2 | Reception complete, bit n = UARTn |
| uart_tx_done | input | 2 | Transmission complete, bit n = UARTn |
| sio_done | input | 1 | Serial port transfer complete |
| tmr_ovf | input | 5 | Timer/counter events, bit n = Tn |
| adc_done | input | 1 | Conversion complete |
| wdt_evt | input | 1 | Watchdog event |
| wt_evt | input | 1 | Watch timer event |
| bit_ovf | input | 1 | Interval timer overflow |
| cpu_ack | input | 1 | One-cycle acknowledge of the presented request |
| irq_req | output | 1 | Level request to the CPU |
| irq_idx | output | 4 | Slot index of the winner, 0 when none |

## Verification
The bench sets several flags at once and acknowledges them one at a time. An arbiter with a wrong order, or an acknowledge that clears the wrong flag, shows up as an unexpected index or flag byte. It loads flags with their enables off, and then with the master enable off, where a leaky gate would raise a request. The shared watchdog slot is tested with only one of its two enables set, which exposes a design that ORs the raw flags or clears both on acknowledge. It also hits a stray acknowledge with nothing pending and a pulse that collides with a software clear. A design that is wrong in these cases either drops the master enable for nothing or loses a fresh event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int NFLAG = 16;
  localparam int NSLOT = 16;
  localparam int IDXW  = 4;
  localparam int NDIR  = 4;

  // Flag bit positions inside the 16-bit {high,low} vector
  localparam int B_WDT = 2;
  localparam int B_WT  = 1;
  localparam int B_BIT = 0;
  localparam int S_WDG = 14;
  localparam int S_BIT = 15;

  // Qualified flags -> slot vector (slot 0 is reset, never requested here)
  function automatic logic [NSLOT-1:0] slot_pending(input logic [NFLAG-1:0] live);
    logic [NSLOT-1:0] s;
    s = '0;
    for (int k = 1; k <= 13; k++) s[k] = live[NFLAG-k];
    s[S_WDG] = live[B_WDT] | live[B_WT];
    s[S_BIT] = live[B_BIT];
    return s;
  endfunction

  // Lowest-numbered pending slot, 0 when none
  function automatic logic [IDXW-1:0] first_slot(input logic [NSLOT-1:0] s);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSLOT-1; i >= 1; i--) if (s[i]) r = IDXW'(i);
    return r;
  endfunction

  // Flag bit to clear when slot idx is acknowledged
  function automatic logic [NFLAG-1:0] slot_clear(input logic [IDXW-1:0] idx,
                                                   input logic [NFLAG-1:0] live);
    logic [NFLAG-1:0] c;
    c = '0;
    if (idx == IDXW'(S_WDG)) begin
      if (live[B_WDT]) c[B_WDT] = 1'b1;
      else             c[B_WT]  = 1'b1;
    end else if (idx == IDXW'(S_BIT)) begin
      c[B_BIT] = 1'b1;
    end else if (idx != '0) begin
      c[NFLAG - int'(idx)] = 1'b1;
    end
    return c;
  endfunction

endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] swclr_i,
  input  logic [N-1:0] hwclr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flags_o[g] <= 1'b0;
      else if (set_i[g])                flags_o[g] <= 1'b1;
      else if (swclr_i[g] | hwclr_i[g]) flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int         DW       = 8,
  parameter int         AW       = 8,
  parameter int         NDIR     = 4,
  parameter int         MSTR_BIT = 2,
  parameter logic [7:0] A_ENH    = 8'hEA,
  parameter logic [7:0] A_ENL    = 8'hEB,
  parameter logic [7:0] A_FLH    = 8'hEC,
  parameter logic [7:0] A_FLL    = 8'hED,
  parameter logic [7:0] A_DIR    = 8'hEE,
  parameter logic [7:0] A_MST    = 8'hEF,
  localparam int        FW       = 2*DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [FW-1:0]   flags_i,
  input  logic [NDIR-1:0] dir_i,
  input  logic            ack_fire,
  output logic [FW-1:0]   en_o,
  output logic            master_o,
  output logic [FW-1:0]   flag_swclr_o,
  output logic [NDIR-1:0] dir_swclr_o
);
  logic wr_enh, wr_enl, wr_flh, wr_fll, wr_dir, wr_mst;

  assign wr_enh = bus_wr && (bus_addr == AW'(A_ENH));
  assign wr_enl = bus_wr && (bus_addr == AW'(A_ENL));
  assign wr_flh = bus_wr && (bus_addr == AW'(A_FLH));
  assign wr_fll = bus_wr && (bus_addr == AW'(A_FLL));
  assign wr_dir = bus_wr && (bus_addr == AW'(A_DIR));
  assign wr_mst = bus_wr && (bus_addr == AW'(A_MST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= '0;
    end else begin
      if (wr_enh) en_o[FW-1:DW] <= bus_wdata;
      if (wr_enl) en_o[DW-1:0]  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      master_o <= 1'b0;
    else if (ack_fire) master_o <= 1'b0;
    else if (wr_mst) master_o <= bus_wdata[MSTR_BIT];
  end

  always_comb begin
    flag_swclr_o = '0;
    if (wr_flh) flag_swclr_o[FW-1:DW] = ~bus_wdata;
    if (wr_fll) flag_swclr_o[DW-1:0]  = ~bus_wdata;
    dir_swclr_o = wr_dir ? ~bus_wdata[NDIR-1:0] : '0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_ENH): bus_rdata = en_o[FW-1:DW];
      AW'(A_ENL): bus_rdata = en_o[DW-1:0];
      AW'(A_FLH): bus_rdata = flags_i[FW-1:DW];
      AW'(A_FLL): bus_rdata = flags_i[DW-1:0];
      AW'(A_DIR): bus_rdata[NDIR-1:0] = dir_i;
      AW'(A_MST): bus_rdata[MSTR_BIT] = master_o;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] en_i,
  input  logic             master_i,
  input  logic             ack_i,
  output logic [NSLOT-1:0] slot_vec_o,
  output logic             req_o,
  output logic [IDXW-1:0]  idx_o,
  output logic             ack_fire_o,
  output logic [NFLAG-1:0] ackclr_o
);
  logic [NFLAG-1:0] live;

  assign live       = flags_i & en_i;
  assign slot_vec_o = slot_pending(live);
  assign idx_o      = first_slot(slot_vec_o);
  assign req_o      = master_i && (slot_vec_o != '0);
  assign ack_fire_o = ack_i && req_o;
  assign ackclr_o   = ack_fire_o ? slot_clear(idx_o, live) : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3:0]    ext_irq,
  input  logic [1:0]    uart_rx_done,
  input  logic [1:0]    uart_tx_done,
  input  logic          sio_done,
  input  logic [4:0]    tmr_ovf,
  input  logic          adc_done,
  input  logic          wdt_evt,
  input  logic          wt_evt,
  input  logic          bit_ovf,
  input  logic          cpu_ack,
  output logic          irq_req,
  output logic [3:0]    irq_idx
);
  logic [NFLAG-1:0] set_vec, flags_q, en_q, swclr, ackclr;
  logic [NDIR-1:0]  dir_set, dir_q, dir_swclr;
  logic [NSLOT-1:0] slot_vec;
  logic             master_q, ack_fire;

  // Flag vector order: high byte INT0..T0, low byte T1..BIT
  assign set_vec = {ext_irq[0], ext_irq[1], ext_irq[2], ext_irq[3],
                    uart_rx_done[0] | uart_tx_done[0],
                    uart_rx_done[1] | uart_tx_done[1],
                    sio_done, tmr_ovf[0],
                    tmr_ovf[1], tmr_ovf[2], tmr_ovf[3], tmr_ovf[4],
                    adc_done, wdt_evt, wt_evt, bit_ovf};
  assign dir_set = {uart_tx_done[1], uart_rx_done[1], uart_tx_done[0], uart_rx_done[0]};

  irqc_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .swclr_i(swclr),
    .hwclr_i(ackclr), .flags_o(flags_q));

  irqc_flags #(.N(NDIR)) u_dir (
    .clk(clk), .rst_n(rst_n), .set_i(dir_set), .swclr_i(dir_swclr),
    .hwclr_i('0), .flags_o(dir_q));

  irqc_regs #(.DW(DW), .AW(AW), .NDIR(NDIR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags_i(flags_q),
    .dir_i(dir_q), .ack_fire(ack_fire), .en_o(en_q), .master_o(master_q),
    .flag_swclr_o(swclr), .dir_swclr_o(dir_swclr));

  irqc_arb u_arb (
    .flags_i(flags_q), .en_i(en_q), .master_i(master_q), .ack_i(cpu_ack),
    .slot_vec_o(slot_vec), .req_o(irq_req), .idx_o(irq_idx),
    .ack_fire_o(ack_fire), .ackclr_o(ackclr));
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic [3:0]  irq_idx,
  input logic        cpu_ack,
  input logic        bus_wr,
  input logic        master_q,
  input logic [15:0] slot_vec,
  input logic [15:0] set_vec,
  input logic [15:0] flags_q,
  input logic [15:0] ackclr
);
  a_r5_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q |-> !irq_req);

  a_r12_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vec == 16'd0) |-> (irq_idx == 4'd0));

  a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (slot_vec[irq_idx] && irq_idx != 4'd0));

  a_r6_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((slot_vec & ((16'd1 << irq_idx) - 16'd1)) == 16'd0));

  a_r8_ack_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req) |=> !master_q);

  a_r8_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ackclr));

  a_r9_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !irq_req && !bus_wr) |=> ($stable(master_q) && ($past(flags_q) & ~flags_q) == 16'd0));

  a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 16'd0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
endmodule

bind irqc_top irqc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_idx(irq_idx),
  .cpu_ack(cpu_ack), .bus_wr(bus_wr), .master_q(master_q),
  .slot_vec(slot_vec), .set_vec(set_vec), .flags_q(flags_q), .ackclr(ackclr));

// File: tb/irqc_tb.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic       bus_wr = 1'b0;
  logic [3:0] ext_irq = '0;
  logic [1:0] uart_rx_done = '0, uart_tx_done = '0;
  logic       sio_done = 1'b0, adc_done = 1'b0, wdt_evt = 1'b0, wt_evt = 1'b0, bit_ovf = 1'b0;
  logic [4:0] tmr_ovf = '0;
  logic       cpu_ack = 1'b0;
  logic       irq_req;
  logic [3:0] irq_idx;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top dut_i (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic clean();
    wr(8'hEF, 8'h00); wr(8'hEA, 8'h00); wr(8'hEB, 8'h00);
    wr(8'hEC, 8'h00); wr(8'hED, 8'h00); wr(8'hEE, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 8'hEA; a <= 8'hEF; a++) begin
      rd(8'(a), d); check("R1 reg", d, 8'h00);
    end
    check("R1 irq_req", {7'd0, irq_req}, 8'h00);
    check("R12 idx", {4'd0, irq_idx}, 8'h00);
  endtask

  task automatic t_enables();
    logic [7:0] d;
    wr(8'hEA, 8'hA5); wr(8'hEB, 8'h3C);
    rd(8'hEA, d); check("R3 high enable", d, 8'hA5);
    rd(8'hEB, d); check("R3 low enable", d, 8'h3C);
    clean();
  endtask

  task automatic t_masked();
    logic [7:0] d;
    @(negedge clk); ext_irq[2] = 1'b1; bit_ovf = 1'b1;
    @(negedge clk); ext_irq[2] = 1'b0; bit_ovf = 1'b0;
    rd(8'hEC, d); check("R2 INT2 flag", d, 8'h20);
    rd(8'hED, d); check("R2 BIT flag", d, 8'h01);
    wr(8'hEF, 8'h04);
    check("R4 disabled no req", {7'd0, irq_req}, 8'h00);
    wr(8'hEF, 8'h00); wr(8'hEA, 8'hFF); wr(8'hEB, 8'hFF);
    check("R5 master off", {7'd0, irq_req}, 8'h00);
    wr(8'hEF, 8'h04);
    check("R5 master on req", {7'd0, irq_req}, 8'h01);
    check("R6 INT2 idx", {4'd0, irq_idx}, 8'd3);
    clean();
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(8'hEA, 8'hFF); wr(8'hEB, 8'hFF);
    @(negedge clk); ext_irq[2] = 1'b1; tmr_ovf[0] = 1'b1; adc_done = 1'b1;
    @(negedge clk); ext_irq = '0; tmr_ovf = '0; adc_done = 1'b0;
    wr(8'hEF, 8'h04);
    check("R6 first INT2", {4'd0, irq_idx}, 8'd3);
    ack();
    rd(8'hEC, d); check("R8 INT2 cleared T0 kept", d, 8'h01);
    rd(8'hEF, d); check("R8 master cleared", d, 8'h00);
    check("R8 req low", {7'd0, irq_req}, 8'h00);
    wr(8'hEF, 8'h04);
    check("R6 then T0", {4'd0, irq_idx}, 8'd8);
    ack(); wr(8'hEF, 8'h04);
    check("R6 then ADC", {4'd0, irq_idx}, 8'd13);
    ack();
    rd(8'hED, d); check("R8 ADC cleared", d, 8'h00);
    check("R12 none idx", {4'd0, irq_idx}, 8'd0);
    clean();
  endtask

  task automatic t_stray();
    logic [7:0] d;
    wr(8'hEB, 8'h00);
    @(negedge clk); tmr_ovf[4] = 1'b1;
    @(negedge clk); tmr_ovf[4] = 1'b0;
    wr(8'hEF, 8'h04);
    ack();
    rd(8'hED, d); check("R9 flag kept", d, 8'h10);
    rd(8'hEF, d); check("R9 master kept", d, 8'h04);
    clean();
  endtask

  task automatic t_watch();
    logic [7:0] d;
    wr(8'hEB, 8'h02); wr(8'hEF, 8'h04);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    check("R7 WDT disabled no req", {7'd0, irq_req}, 8'h00);
    @(negedge clk); wt_evt = 1'b1;
    @(negedge clk); wt_evt = 1'b0;
    check("R7 WT req", {7'd0, irq_req}, 8'h01);
    check("R7 slot 14", {4'd0, irq_idx}, 8'd14);
    ack();
    rd(8'hED, d); check("R7 WT cleared WDT kept", d, 8'h04);
    clean();
  endtask

  task automatic t_swclr();
    logic [7:0] d;
    @(negedge clk); tmr_ovf[1] = 1'b1; adc_done = 1'b1;
    @(negedge clk); tmr_ovf[1] = 1'b0; adc_done = 1'b0;
    wr(8'hED, 8'hFF);
    rd(8'hED, d); check("R10 write ones keeps", d, 8'h88);
    wr(8'hED, 8'h80);
    rd(8'hED, d); check("R10 zero clears", d, 8'h80);
    wr(8'hED, 8'h00);
    rd(8'hED, d); check("R10 all clear", d, 8'h00);
    @(negedge clk); bus_addr = 8'hED; bus_wdata = 8'h00; bus_wr = 1'b1; bit_ovf = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bit_ovf = 1'b0;
    rd(8'hED, d); check("R10 pulse beats clear", d, 8'h01);
    clean();
  endtask

  task automatic t_uart();
    logic [7:0] d;
    @(negedge clk); uart_tx_done[1] = 1'b1;
    @(negedge clk); uart_tx_done[1] = 1'b0;
    rd(8'hEC, d); check("R11 UART1 flag", d, 8'h04);
    rd(8'hEE, d); check("R11 UART1 tx dir", d, 8'h08);
    @(negedge clk); uart_rx_done[0] = 1'b1;
    @(negedge clk); uart_rx_done[0] = 1'b0;
    rd(8'hEC, d); check("R11 UART0 flag", d, 8'h0C);
    rd(8'hEE, d); check("R11 UART0 rx dir", d, 8'h09);
    wr(8'hEE, 8'h01);
    rd(8'hEE, d); check("R11 dir clear", d, 8'h01);
    clean();
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_masked();
    t_priority();
    t_stray();
    t_watch();
    t_swclr();
    t_uart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule